// File: doc/BRIEF.md
# Serial Receiver Status Flags

This block keeps the receive-side status of an asynchronous serial channel. A shift register outside the block assembles each incoming byte and pulses a strobe. The strobe carries the byte and its parity and framing error indications. The block moves that byte into a single holding register and tracks four flags: receive full, overrun, parity error and framing error. It also keeps three software enable bits and mirrors a transmit-empty input. All of these are packed into one 8-bit status byte.

Reading the holding register empties it. The three error flags are sticky. They are cleared only by writing the error-reset control bit with the value 0. A high carrier-detect input or the stop-mode input clears all four flags, in the same way as reset, and refuses new bytes for as long as either one is asserted. A receive interrupt request is formed from the receive enable bit and the four flags.

Top module: `serrx_status`

## Requirements
- R1: After reset the status byte reads 0 in bits 7..2 and bit 0, bit 1 equals `tx_empty`, and `rx_irq` is 0.
- R2: A `byte_done` pulse, with the holding register empty and no hold condition, loads `byte_data` into `rx_data` and sets bit 7 (receive full). Both are visible after the clock edge that samples the pulse.
- R3: A byte flagged with a parity or framing error is still loaded, and it still sets bit 7.
- R4: A `data_rd` pulse clears bit 7. If `data_rd` and `byte_done` occur in the same cycle, the new byte is loaded and bit 7 stays 1.
- R5: A `byte_done` pulse while bit 7 is 1 and `data_rd` is 0 sets bit 6 (overrun). `rx_data` then keeps its earlier byte and the new byte is discarded.
- R6: Bit 5 (parity error) is set by a loaded byte with `byte_par_err`=1 only when `parity_en` is 1.
- R7: Bit 4 (framing error) is set by a loaded byte with `byte_frm_err`=1, whatever the value of `parity_en`.
- R8: Bits 6, 5 and 4 clear only on a `ctl_wr` pulse with `ctl_errclr`=0, or on a hold condition or reset. A `ctl_wr` with `ctl_errclr`=1 and a `data_rd` leave them unchanged. In a cycle where a flag is both set and cleared, the set takes effect.
- R9: While `carrier_hi` or `stop_mode` is 1, bits 7..4 clear and `byte_done` pulses are ignored, so `rx_data` does not change.
- R10: A `stat_wr` pulse writes `stat_wdata` bits 3, 2 and 0 into the receive interrupt enable, CTS enable and transmit interrupt enable bits. Bits 7..4 and 1 of the written value have no effect.
- R11: Status bit 1 follows the `tx_empty` input.
- R12: `rx_irq` is 1 exactly when status bit 3 is 1 and at least one of bits 7..4 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_done | input | 1 | Shift register has completed a byte (one-cycle strobe) |
| byte_data | input | 8 | Completed byte |
| byte_par_err | input | 1 | Parity mismatch on the completed byte |
| byte_frm_err | input | 1 | Missing stop bit on the completed byte |
| parity_en | input | 1 | Mode bit that enables parity checking |
| data_rd | input | 1 | Read strobe for the holding register |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_errclr | input | 1 | Error-reset bit value carried by the control write |
| stat_wr | input | 1 | Write strobe for the status enable bits |
| stat_wdata | input | 8 | Value written to the status byte |
| carrier_hi | input | 1 | Carrier-detect input, high means no carrier |
| stop_mode | input | 1 | Stop mode of the I/O system |
| tx_empty | input | 1 | Transmit data register empty, from the transmit side |
| rx_data | output | 8 | Holding register contents |
| status | output | 8 | Status byte |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
A wrong full flag shows in the cycle after the strobe that caused it. It appears as bit 7 of the status byte and as a wrong `rx_irq`. A wrong overrun decision is caught by checking two things on the same edge: that bit 6 is set and that `rx_data` still holds the earlier byte. A wrong clear rule for the sticky error bits stays hidden until the bench issues a non-clearing write or a read, so these are checked right after each stimulus. The hold inputs are checked both for clearing the flags and for blocking loads, with `rx_data` read while the hold is still asserted.

// File: rtl/serrx_pkg.sv
// Package: shared status layout for the serial receive status block.
// Assumes an 8-bit status byte whose bit order software decodes.
package serrx_pkg;
    localparam int STAT_W = 8;

    // Status byte layout, most significant field first.
    typedef struct packed {
        logic rx_full;   // bit 7
        logic overrun;   // bit 6
        logic par_err;   // bit 5
        logic frm_err;   // bit 4
        logic rx_ie;     // bit 3
        logic cts_en;    // bit 2
        logic tx_empty;  // bit 1
        logic tx_ie;     // bit 0
    } stat_t;

    localparam int BIT_RXIE = 3;
    localparam int BIT_CTSE = 2;
    localparam int BIT_TXIE = 0;

    // Index of each sticky error flag in the error flag vector.
    localparam int NUM_ERR = 3;
    localparam int ERR_OVR = 2;
    localparam int ERR_PAR = 1;
    localparam int ERR_FRM = 0;
endpackage

// File: rtl/serrx_hold_reg.sv
// Module: receive data holding register with its full flag.
// Accepts a byte on load_req, empties on rd_req. The caller decides
// acceptance: it asserts load_req only when the byte is to be taken.
// A hold input clears the flag; the stored data is left untouched.
module serrx_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              load_req,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              full
);
    // Capture the accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= '0;
        else if (load_req)
            dout <= din;
    end

    // Full flag: hold clears, a load beats a read in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            full <= 1'b0;
        else if (hold)
            full <= 1'b0;
        else if (load_req)
            full <= 1'b1;
        else if (rd_req)
            full <= 1'b0;
    end
endmodule

// File: rtl/serrx_err_flags.sv
// Module: bank of sticky error flags.
// Each flag sets on its own set bit and clears on a shared software clear
// or on the hold condition. A set in the same cycle as a software clear
// wins, so no error event is lost. Assumes set bits are single-cycle events.
module serrx_err_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         sw_clr,
    input  logic [N-1:0] set,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Per-flag sticky register with hold-clear priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (hold)
                flags[i] <= 1'b0;
            else if (set[i])
                flags[i] <= 1'b1;
            else if (sw_clr)
                flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/serrx_enable_regs.sv
// Module: software enable bits of the status byte.
// Only the receive interrupt, CTS and transmit interrupt enable positions
// are writable; the other written bits are dropped. The hold condition
// does not touch these bits; only reset does.
module serrx_enable_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic         rx_ie,
    output logic         cts_en,
    output logic         tx_ie
);
    // Write the three enable bits from their fixed positions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_ie  <= 1'b0;
            cts_en <= 1'b0;
            tx_ie  <= 1'b0;
        end else if (wr) begin
            rx_ie  <= wdata[serrx_pkg::BIT_RXIE];
            cts_en <= wdata[serrx_pkg::BIT_CTSE];
            tx_ie  <= wdata[serrx_pkg::BIT_TXIE];
        end
    end
endmodule

// File: rtl/serrx_status.sv
// Module: receive status logic of an asynchronous serial channel (top).
// Takes completed bytes from an external shift register, keeps one holding
// register and the full/overrun/parity/framing flags, and packs them with
// the enable bits and the transmit-empty input into one status byte.
// Assumes all strobes are one cycle wide and synchronous to clk.
module serrx_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              byte_par_err,
    input  logic              byte_frm_err,
    input  logic              parity_en,
    input  logic              data_rd,
    input  logic              ctl_wr,
    input  logic              ctl_errclr,
    input  logic              stat_wr,
    input  logic [7:0]        stat_wdata,
    input  logic              carrier_hi,
    input  logic              stop_mode,
    input  logic              tx_empty,
    output logic [DATA_W-1:0] rx_data,
    output logic [7:0]        status,
    output logic              rx_irq
);
    import serrx_pkg::*;

    logic                hold;
    logic                full;
    logic                accept;
    logic                ovr_evt;
    logic                sw_clr;
    logic [NUM_ERR-1:0]  err_set;
    logic [NUM_ERR-1:0]  err_q;
    logic                rx_ie, cts_en, tx_ie;
    stat_t               stat_s;

    // Decide acceptance, overrun and flag events for this cycle.
    always_comb begin
        hold    = carrier_hi | stop_mode;
        accept  = byte_done & ~hold & (~full | data_rd);
        ovr_evt = byte_done & ~hold & full & ~data_rd;
        sw_clr  = ctl_wr & ~ctl_errclr;
        err_set          = '0;
        err_set[ERR_OVR] = ovr_evt;
        err_set[ERR_PAR] = accept & parity_en & byte_par_err;
        err_set[ERR_FRM] = accept & byte_frm_err;
    end

    serrx_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .load_req (accept),
        .rd_req   (data_rd),
        .din      (byte_data),
        .dout     (rx_data),
        .full     (full)
    );

    serrx_err_flags #(.N(NUM_ERR)) u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (hold),
        .sw_clr (sw_clr),
        .set    (err_set),
        .flags  (err_q)
    );

    serrx_enable_regs #(.W(STAT_W)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (stat_wr),
        .wdata  (stat_wdata),
        .rx_ie  (rx_ie),
        .cts_en (cts_en),
        .tx_ie  (tx_ie)
    );

    // Pack the status byte and form the receive interrupt request.
    always_comb begin
        stat_s.rx_full  = full;
        stat_s.overrun  = err_q[ERR_OVR];
        stat_s.par_err  = err_q[ERR_PAR];
        stat_s.frm_err  = err_q[ERR_FRM];
        stat_s.rx_ie    = rx_ie;
        stat_s.cts_en   = cts_en;
        stat_s.tx_empty = tx_empty;
        stat_s.tx_ie    = tx_ie;
        status = stat_s;
        rx_irq = rx_ie & (full | (|err_q));
    end
endmodule

// File: rtl/serrx_status_chk.sv
// Checker: port-level properties of serrx_status, bound to every instance.
module serrx_status_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_done,
    input logic              data_rd,
    input logic              parity_en,
    input logic              ctl_wr,
    input logic              ctl_errclr,
    input logic              carrier_hi,
    input logic              stop_mode,
    input logic              tx_empty,
    input logic [DATA_W-1:0] rx_data,
    input logic [7:0]        status,
    input logic              rx_irq
);
    AST_FULL_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !carrier_hi && !stop_mode) |=> status[7]); // R2
    AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && status[7] && !data_rd && !carrier_hi && !stop_mode)
        |=> (status[6] && $stable(rx_data))); // R5
    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !byte_done && !carrier_hi && !stop_mode) |=> !status[7]); // R4
    AST_PAR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (!parity_en && !status[5]) |=> !status[5]); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[4] && !(ctl_wr && !ctl_errclr) && !carrier_hi && !stop_mode)
        |=> status[4]); // R8
    AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier_hi || stop_mode) |=> (status[7:4] == 4'b0000)); // R9
    AST_TXE_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] == tx_empty); // R11
    AST_IRQ_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq == (status[3] && (status[7:4] != 4'b0000))); // R12
endmodule

bind serrx_status serrx_status_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_done  (byte_done),
    .data_rd    (data_rd),
    .parity_en  (parity_en),
    .ctl_wr     (ctl_wr),
    .ctl_errclr (ctl_errclr),
    .carrier_hi (carrier_hi),
    .stop_mode  (stop_mode),
    .tx_empty   (tx_empty),
    .rx_data    (rx_data),
    .status     (status),
    .rx_irq     (rx_irq)
);

// File: tb/serrx_status_tb.sv
// Directed bench for serrx_status: inputs change on the falling edge,
// outputs are checked on the following falling edge.
module serrx_status_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_done = 1'b0;
    logic [7:0] byte_data = '0;
    logic       byte_par_err = 1'b0, byte_frm_err = 1'b0, parity_en = 1'b0;
    logic       data_rd = 1'b0, ctl_wr = 1'b0, ctl_errclr = 1'b1;
    logic       stat_wr = 1'b0;
    logic [7:0] stat_wdata = '0;
    logic       carrier_hi = 1'b0, stop_mode = 1'b0, tx_empty = 1'b1;
    logic [7:0] rx_data, status;
    logic       rx_irq;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    serrx_status u_dut (
        .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .byte_data(byte_data),
        .byte_par_err(byte_par_err), .byte_frm_err(byte_frm_err),
        .parity_en(parity_en), .data_rd(data_rd), .ctl_wr(ctl_wr),
        .ctl_errclr(ctl_errclr), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .carrier_hi(carrier_hi), .stop_mode(stop_mode), .tx_empty(tx_empty),
        .rx_data(rx_data), .status(status), .rx_irq(rx_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One cycle of stimulus, then strobes drop; results are visible after it.
    task automatic step();
        @(negedge clk);
        byte_done = 1'b0; data_rd = 1'b0; ctl_wr = 1'b0; stat_wr = 1'b0;
        byte_par_err = 1'b0; byte_frm_err = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input logic pe, input logic fe, input logic rd);
        byte_done = 1'b1; byte_data = d; byte_par_err = pe; byte_frm_err = fe;
        data_rd = rd;
        step();
    endtask

    task automatic rd();
        data_rd = 1'b1;
        step();
    endtask

    task automatic ctl(input logic v);
        ctl_wr = 1'b1; ctl_errclr = v;
        step();
    endtask

    task automatic t_reset();
        check("R1 status after reset", status, 8'h02);
        check("R1 irq after reset", {7'd0, rx_irq}, 8'h00);
        check("R11 tx_empty mirror", {7'd0, status[1]}, 8'h01);
    endtask

    task automatic t_load();
        send(8'hA5, 1'b0, 1'b0, 1'b0);
        check("R2 data loaded", rx_data, 8'hA5);
        check("R2 full set", status, 8'h82);
        rd();
        check("R4 read clears full", {7'd0, status[7]}, 8'h00);
    endtask

    task automatic t_parity();
        parity_en = 1'b1;
        send(8'h3C, 1'b1, 1'b0, 1'b0);
        check("R3 error byte loaded", rx_data, 8'h3C);
        check("R3 R6 full and parity flag", status[7:4], 8'h0A);
        rd();
        check("R8 read leaves parity flag", status[7:4], 8'h02);
        ctl(1'b0);
        check("R8 clear by writing 0", status[7:4], 8'h00);
        parity_en = 1'b0;
        send(8'h5A, 1'b1, 1'b0, 1'b0);
        check("R6 parity ignored when disabled", status[7:4], 8'h08);
        rd();
    endtask

    task automatic t_framing();
        parity_en = 1'b0;
        send(8'h77, 1'b0, 1'b1, 1'b0);
        check("R7 framing flag without parity_en", status[7:4], 8'h09);
        ctl(1'b1);
        check("R8 write of 1 keeps framing flag", status[7:4], 8'h09);
        rd();
        check("R8 read keeps framing flag", status[7:4], 8'h01);
        ctl(1'b0);
        check("R8 framing cleared", status[7:4], 8'h00);
    endtask

    task automatic t_overrun();
        send(8'h11, 1'b0, 1'b0, 1'b0);
        send(8'h22, 1'b0, 1'b0, 1'b0);
        check("R5 overrun flag", status[7:4], 8'h0C);
        check("R5 old byte kept", rx_data, 8'h11);
        send(8'h33, 1'b0, 1'b0, 1'b1);
        check("R4 load wins over read", rx_data, 8'h33);
        check("R4 full stays set", {7'd0, status[7]}, 8'h01);
        ctl(1'b0);
        rd();
        check("R8 overrun cleared", status[7:4], 8'h00);
    endtask

    task automatic t_hold();
        send(8'h44, 1'b0, 1'b1, 1'b0);
        carrier_hi = 1'b1;
        step();
        check("R9 carrier clears flags", status[7:4], 8'h00);
        send(8'h55, 1'b0, 1'b0, 1'b0);
        check("R9 load blocked under carrier", rx_data, 8'h44);
        check("R9 full stays clear", {7'd0, status[7]}, 8'h00);
        carrier_hi = 1'b0;
        send(8'h66, 1'b1, 1'b1, 1'b0);
        stop_mode = 1'b1;
        step();
        check("R9 stop mode clears flags", status[7:4], 8'h00);
        send(8'h67, 1'b0, 1'b0, 1'b0);
        check("R9 load blocked in stop mode", rx_data, 8'h66);
        stop_mode = 1'b0;
        step();
    endtask

    task automatic t_enables();
        stat_wr = 1'b1; stat_wdata = 8'hFF;
        step();
        check("R10 only enable bits written", status, 8'h0F);
        check("R12 no irq without flags", {7'd0, rx_irq}, 8'h00);
        send(8'h12, 1'b0, 1'b0, 1'b0);
        check("R12 irq on full", {7'd0, rx_irq}, 8'h01);
        tx_empty = 1'b0;
        step();
        check("R11 tx_empty low", status, 8'h8D);
        stat_wr = 1'b1; stat_wdata = 8'h00;
        step();
        check("R10 enables cleared", status, 8'h80);
        check("R12 irq off with enable 0", {7'd0, rx_irq}, 8'h00);
        rd();
        tx_empty = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_parity();
        t_framing();
        t_overrun();
        t_hold();
        t_enables();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule